// File: doc/BRIEF.md
# UART Receive Queue with Trigger Level and Character Timeout

This block is the receive half of a 16550-style serial port. It sits behind a bit deserialiser, which hands it one byte at a time together with break events. Software reads the buffered bytes through a one-byte read port. The block keeps the status that such a port reports: data-ready, break, overrun, the number of bytes held, the programmed trigger level and a pending character-timeout flag.

The queue runs in one of two modes. In buffered mode it holds up to 16 bytes. An arrival into a full queue is dropped and the bytes already held stay intact. A timer counts bit-time ticks. When bytes sit unread for four whole character frames, it raises a timeout flag. The frame length follows the current line-format word. In single-byte mode a lone holding register stands in for the queue, and a new byte overwrites an unread one.

A control write plays the role of the FIFO control register. Bit 0 selects buffered mode. Bit 1 requests a receive flush. Bits 7:6 choose the trigger level. Only bits 7, 6, 3 and 0 are retained. Everything is synchronous to one clock and uses a synchronous active-high reset.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the block is in single-byte mode with control value 0. Data-ready, break, overrun and timeout-pending are 0, the count is 0 and the trigger level reads 1.
- R2: The trigger level follows control bits 7:6: code 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14.
- R3: In buffered mode, bytes are read out in arrival order. Each read takes one byte off and shows it on rd_data from the clock edge after rd_en. The count tracks the bytes held, up to 16.
- R4: A byte that arrives while the queue holds 16 bytes is discarded. The held bytes and the count are unchanged, and overrun is set.
- R5: A buffered-mode read of an empty queue returns 0. Data-ready and break clear when a read leaves the queue empty, and not before.
- R6: A break event stores a zero byte, under the same overflow rule as R4, and sets both break and data-ready.
- R7: In buffered mode, timeout-pending is set when data has stayed in the queue for 4 x F bit ticks after the last arrival. F = 1 + (5 + line_fmt[1:0]) + line_fmt[3] + (line_fmt[2] ? 2 : 1). The flag appears two clock edges after the final tick.
- R8: Any read clears timeout-pending. A read that leaves data behind restarts the 4 x F tick window.
- R9: A control write with bit 1 set empties the queue and clears data-ready, break and timeout-pending. Overrun is left as it was.
- R10: A control write that changes bit 0 flushes as in R9. A control write with bit 1 clear and bit 0 unchanged keeps the held data, because bits 1 and 2 are not retained.
- R11: In single-byte mode, a byte that arrives while data-ready is set overwrites the held byte and sets overrun. A read returns the held byte and clears data-ready and break.
- R12: A pulse on stat_clr clears break and overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present on rx_data |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | One-cycle strobe: a break condition was detected on the line |
| rd_en | input | 1 | Read strobe for the receive buffer |
| rd_data | output | 8 | Byte returned by the last read |
| stat_clr | input | 1 | Status-read strobe; clears break and overrun |
| fcr_we | input | 1 | Control register write strobe |
| fcr_wdata | input | 8 | Control write value: bit 0 enable, bit 1 flush, bits 7:6 trigger code |
| line_fmt | input | 4 | Line format: [1:0] data bits minus 5, [2] two stop bits, [3] parity present |
| bit_tick | input | 1 | One pulse per serial bit time |
| data_ready | output | 1 | Received data available |
| brk_flag | output | 1 | Break indicator |
| ovr_flag | output | 1 | Overrun indicator |
| fifo_count | output | 5 | Bytes held in the queue |
| trig_level | output | 5 | Trigger level in bytes |
| timeout_pend | output | 1 | Character timeout pending |

## Verification
A wrong pointer or count shows up at the next read: a byte comes back out of order, or in the wrong number. It also shows up at once on fifo_count. A wrong timer limit moves the rise of timeout_pend off by a tick or more for some line format. The bench sweeps all sixteen formats, so a one-tick error shows within that sweep. Status flags that are mishandled show up one edge after the event that should have set them or cleared them.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_RST_BIT  = 1;
  localparam logic [7:0] CTL_KEEP = 8'hC9;
  localparam int TO_CHARS     = 4;
  localparam int MAX_FRAME    = 12;

  // Trigger level in bytes for a two-bit code.
  function automatic logic [4:0] trig_bytes(input logic [1:0] code);
    logic [4:0] r;
    case (code)
      2'd0:    r = 5'd1;
      2'd1:    r = 5'd4;
      2'd2:    r = 5'd8;
      default: r = 5'd14;
    endcase
    return r;
  endfunction

  // Bits per character frame for a line format word.
  function automatic logic [3:0] frame_bits(input logic [3:0] fmt);
    return 4'd7 + {2'b00, fmt[1:0]} + {3'b000, fmt[3]} + {3'b000, fmt[2]};
  endfunction
endpackage

// File: rtl/rx_byte_store.sv
module rx_byte_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  q,
  output logic [CW-1:0] count,
  output logic          accepted,
  output logic          dropped,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, pop_ok;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign pop_ok   = pop && !empty && !clr;
  assign accepted = push && !clr && (!full || pop_ok);
  assign dropped  = push && !clr && full && !pop_ok;

  always_ff @(posedge clk) begin
    if (accepted) mem[wptr] <= push_data;
    if (pop_ok)   q <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (accepted) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok)   rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + CW'(accepted) - CW'(pop_ok);
    end
  end

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R4
  drop_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    dropped |=> count == $past(count));
endmodule

// File: rtl/rx_char_timer.sv
module rx_char_timer
  import uart_rx_pkg::*;
#(
  parameter int CHARS   = TO_CHARS,
  parameter int MAXF    = MAX_FRAME,
  localparam int TW     = $clog2(CHARS * MAXF + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] fmt,
  input  logic       tick,
  input  logic       restart,
  input  logic       stop,
  output logic       fire
);
  logic [TW-1:0] cnt, limit;
  logic          armed;

  assign limit = TW'(CHARS * int'(frame_bits(fmt)));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
      fire  <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (stop) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (restart) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed && tick) begin
        if (cnt == limit - 1'b1) begin
          fire  <= 1'b1;
          armed <= 1'b0;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R7
  fire_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(armed) && $past(tick));
  // R8
  restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    restart && !stop |=> !fire);
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_break,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  input  logic          stat_clr,
  input  logic          fcr_we,
  input  logic [7:0]    fcr_wdata,
  input  logic [3:0]    line_fmt,
  input  logic          bit_tick,
  output logic          data_ready,
  output logic          brk_flag,
  output logic          ovr_flag,
  output logic [CW-1:0] fifo_count,
  output logic [CW-1:0] trig_level,
  output logic          timeout_pend
);
  logic [7:0] ctl_q, hold_q, aux_q, mem_q, abyte;
  logic       src_mem_q, buffered, flip, rx_clr, live, arrive, rd;
  logic       push, pop, accepted, dropped, q_empty, fire, restart;
  logic       last_out;
  wire        unused_ctl = ^{fcr_wdata[5:2], ctl_q[5:1]};

  assign buffered = ctl_q[CTL_EN_BIT];
  assign flip     = fcr_we && (fcr_wdata[CTL_EN_BIT] != buffered);
  assign rx_clr   = fcr_we && (fcr_wdata[CTL_RST_BIT] || flip);
  assign live     = !fcr_we;
  assign arrive   = live && (rx_valid || rx_break);
  assign abyte    = rx_break ? 8'h00 : rx_data;
  assign rd       = live && rd_en;
  assign push     = buffered && arrive;
  assign pop      = buffered && rd;
  assign last_out = pop && (fifo_count <= CW'(1)) && !accepted;
  assign restart  = push || (pop && fifo_count > CW'(1));

  rx_byte_store #(.DEPTH(DEPTH), .W(8)) u_store (
    .clk(clk), .rst(rst), .clr(rx_clr), .push(push), .push_data(abyte),
    .pop(pop), .q(mem_q), .count(fifo_count), .accepted(accepted),
    .dropped(dropped), .empty(q_empty)
  );

  rx_char_timer u_timer (
    .clk(clk), .rst(rst), .fmt(line_fmt), .tick(bit_tick),
    .restart(restart), .stop(rx_clr), .fire(fire)
  );

  assign trig_level = CW'(trig_bytes(ctl_q[7:6]));
  assign rd_data    = src_mem_q ? mem_q : aux_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q        <= '0;
      hold_q       <= '0;
      aux_q        <= '0;
      src_mem_q    <= 1'b0;
      data_ready   <= 1'b0;
      brk_flag     <= 1'b0;
      ovr_flag     <= 1'b0;
      timeout_pend <= 1'b0;
    end else begin
      if (fcr_we) ctl_q <= fcr_wdata & CTL_KEEP;

      if (!buffered && arrive) hold_q <= abyte;

      if (rd) begin
        src_mem_q <= buffered && !q_empty;
        aux_q     <= buffered ? 8'h00 : hold_q;
      end

      if (rx_clr)
        data_ready <= 1'b0;
      else if (arrive)
        data_ready <= 1'b1;
      else if (rd && (!buffered || last_out))
        data_ready <= 1'b0;

      if (rx_clr)
        brk_flag <= 1'b0;
      else if (arrive && rx_break)
        brk_flag <= 1'b1;
      else if (stat_clr || (rd && (!buffered || last_out)))
        brk_flag <= 1'b0;

      if (dropped || (!buffered && arrive && data_ready && !rd))
        ovr_flag <= 1'b1;
      else if (stat_clr)
        ovr_flag <= 1'b0;

      if (rx_clr || rd)
        timeout_pend <= 1'b0;
      else if (fire && buffered && fifo_count != '0)
        timeout_pend <= 1'b1;
    end
  end

  // R6
  break_flags_chk: assert property (@(posedge clk) disable iff (rst)
    rx_break && !fcr_we |=> brk_flag && data_ready);
  // R8
  read_clears_to_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && !fcr_we |=> !timeout_pend);
  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    fcr_we && fcr_wdata[CTL_RST_BIT] |=> fifo_count == '0 && !data_ready && !timeout_pend);
  // R10
  mode_flip_chk: assert property (@(posedge clk) disable iff (rst)
    fcr_we && (fcr_wdata[CTL_EN_BIT] != ctl_q[CTL_EN_BIT]) |=> fifo_count == '0 && !data_ready);
  // R7
  pend_has_data_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_pend |-> data_ready && fifo_count != '0);
  // R11
  single_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl_q[CTL_EN_BIT] && rx_valid && data_ready && !rd_en && !fcr_we |=> ovr_flag);
endmodule

// File: tb/sim_uart_rx_queue.sv
module sim_uart_rx_queue;
  localparam int PERIOD = 10;
  logic clk = 0, rst = 1;
  logic rx_valid = 0, rx_break = 0, rd_en = 0, stat_clr = 0, fcr_we = 0, bit_tick = 0;
  logic [7:0] rx_data = 0, fcr_wdata = 0, rd_data;
  logic [3:0] line_fmt = 0;
  logic data_ready, brk_flag, ovr_flag, timeout_pend;
  logic [4:0] fifo_count, trig_level;
  int nrun = 0, nfail = 0;
  logic [7:0] v;

  always #(PERIOD/2) clk = ~clk;

  uart_rx_queue u0 (.clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_break(rx_break), .rd_en(rd_en), .rd_data(rd_data), .stat_clr(stat_clr),
    .fcr_we(fcr_we), .fcr_wdata(fcr_wdata), .line_fmt(line_fmt), .bit_tick(bit_tick),
    .data_ready(data_ready), .brk_flag(brk_flag), .ovr_flag(ovr_flag),
    .fifo_count(fifo_count), .trig_level(trig_level), .timeout_pend(timeout_pend));

  task automatic check(input string req, input int act, input int exp);
    nrun++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1; rx_data = b; @(negedge clk); rx_valid = 0;
  endtask
  task automatic brk();
    rx_break = 1; @(negedge clk); rx_break = 0;
  endtask
  task automatic rd(output logic [7:0] o);
    rd_en = 1; @(negedge clk); rd_en = 0; o = rd_data;
  endtask
  task automatic ctl(input logic [7:0] w);
    fcr_we = 1; fcr_wdata = w; @(negedge clk); fcr_we = 0;
  endtask
  task automatic sclr();
    stat_clr = 1; @(negedge clk); stat_clr = 0;
  endtask
  task automatic ticks(input int n);
    bit_tick = 1; repeat (n) @(negedge clk); bit_tick = 0;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 dr", data_ready, 0); check("R1 bi", brk_flag, 0);
    check("R1 oe", ovr_flag, 0);   check("R1 to", timeout_pend, 0);
    check("R1 cnt", fifo_count, 0); check("R1 trig", trig_level, 1);

    // R11 single-byte mode
    push(8'h11); check("R11 dr set", data_ready, 1);
    rd(v); check("R11 data", v, 8'h11); check("R11 dr clr", data_ready, 0);
    push(8'h22); push(8'h33); check("R11 oe", ovr_flag, 1);
    rd(v); check("R11 overwrite", v, 8'h33);
    sclr(); check("R12 oe clr", ovr_flag, 0);
    brk(); check("R6 bi single", brk_flag, 1);
    rd(v); check("R11 break byte", v, 0); check("R11 bi clr", brk_flag, 0);
    brk(); sclr(); check("R12 bi clr", brk_flag, 0);
    rd(v);

    // R2 trigger sweep (enters buffered mode)
    for (int c = 0; c < 4; c++) begin
      ctl(8'((c << 6) | 3));
      check("R2 trig", trig_level, (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14);
    end

    // R3/R4 fill and order
    ctl(8'h03);
    for (int i = 0; i < 18; i++) begin
      push(8'(i * 7 + 3));
      check("R3 count", fifo_count, (i + 1 > 16) ? 16 : i + 1);
    end
    check("R4 oe", ovr_flag, 1);
    sclr(); check("R12 oe clr fifo", ovr_flag, 0);
    for (int i = 0; i < 16; i++) begin
      rd(v); check("R3 order", v, (i * 7 + 3) & 255);
      check("R5 dr", data_ready, (i < 15) ? 1 : 0);
    end
    rd(v); check("R5 empty read", v, 0); check("R5 cnt", fifo_count, 0);

    // R6 break in buffered mode
    push(8'h5A); brk();
    check("R6 bi", brk_flag, 1); check("R6 dr", data_ready, 1); check("R6 cnt", fifo_count, 2);
    rd(v); check("R3 before break", v, 8'h5A); check("R5 bi held", brk_flag, 1);
    rd(v); check("R6 zero", v, 0); check("R5 bi clr", brk_flag, 0); check("R5 dr clr", data_ready, 0);

    // R7/R8 timeout over every line format
    for (int f = 0; f < 16; f++) begin
      int lim;
      lim = 4 * (7 + (f & 3) + ((f >> 3) & 1) + ((f >> 2) & 1));
      line_fmt = 4'(f);
      ctl(8'h03);
      push(8'(8'hA0 + f));
      ticks(lim - 1); check("R7 early", timeout_pend, 0);
      ticks(1);       check("R7 fire", timeout_pend, 1);
      rd(v); check("R8 clr", timeout_pend, 0); check("R3 to byte", v, (8'hA0 + f) & 255);
    end

    // R8 read that leaves data restarts window (line_fmt 15: F = 12)
    ctl(8'h03); push(8'h01); push(8'h02);
    ticks(46); rd(v);
    ticks(47); check("R8 restart early", timeout_pend, 0);
    ticks(1);  check("R8 restart fire", timeout_pend, 1);

    // R9 flush
    ctl(8'h03);
    check("R9 cnt", fifo_count, 0); check("R9 dr", data_ready, 0); check("R9 to", timeout_pend, 0);

    // R10 keep on non-flip write, flush on flip
    push(8'h10); push(8'h20); push(8'h30);
    ctl(8'hC1); check("R10 keep", fifo_count, 3); check("R10 trig", trig_level, 14);
    rd(v); check("R10 data", v, 8'h10);
    ctl(8'h00); check("R10 flip cnt", fifo_count, 0); check("R10 flip dr", data_ready, 0);

    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule